// File: doc/BRIEF.md
# Dual-Bank Synchronous Bus Exchanger

The block sits between one processor-side data port (A) and two memory-side ports. One memory-side port serves the even bank and the other serves the odd bank. It holds four one-direction data registers: A to even, A to odd, even to A, and odd to A. Each register has its own active-low load enable, sampled on the rising clock edge, and keeps its contents while that enable is high. A typical sequence writes a word into the even bank register, writes a word into the odd bank register, and later reads the captured bank data back onto port A. A return-path select, also sampled on the edge, picks which bank register drives port A.

Each port is split into an input, an output and a drive-enable flag, so a pad ring or a tri-state model can be placed around it. The drive-enable flags are registered copies of two active-low output-enable inputs. One enable serves port A, and one is shared by both bank ports. A change on an enable therefore reaches its port only after the next rising edge. Every output comes straight from a flop, and there is no path from an input to an output that bypasses a flop.

The return-path select is held as a two-state register. State RET_ODD, entered when the select is sampled low, routes the odd-to-A register onto port A. State RET_EVEN, entered when it is sampled high, routes the even-to-A register. The transition RET_ODD to RET_EVEN happens on an edge with the select high. The transition RET_EVEN to RET_ODD happens on an edge with the select low. In every other case the state stays where it is. Reset enters RET_ODD.

Top module: `dual_bank_exchanger`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, every data output is zero and every drive flag is 0.
- R2: A rising edge with `a2even_ld_n` low captures `a_in`, and `even_out` shows the captured value from that edge onward.
- R3: A rising edge with `a2even_ld_n` high leaves `even_out` unchanged.
- R4: A rising edge with `a2odd_ld_n` low captures `a_in` onto `odd_out`. With `a2odd_ld_n` high, `odd_out` is unchanged.
- R5: A rising edge with `even2a_ld_n` low captures `even_in` into the even-to-A register. With it high, that register holds. The register is observed on `a_out` while the even path is selected.
- R6: A rising edge with `odd2a_ld_n` low captures `odd_in` into the odd-to-A register. With it high, that register holds. The register is observed on `a_out` while the odd path is selected.
- R7: `ret_even_sel` is sampled at the rising edge. A value of 1 makes `a_out` show the even-to-A register from that edge on, and a value of 0 makes it show the odd-to-A register.
- R8: `a_drive` equals the inverse of `a_oe_n` as sampled at the most recent rising edge (1 = port A driven).
- R9: `even_drive` and `odd_drive` both equal the inverse of `b_oe_n` as sampled at the most recent rising edge.
- R10: Between rising edges, no output changes, whatever the inputs do.
- R11: The output enables never alter the data registers. Every data output carries its register value whether or not its drive flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 12 | Data arriving on port A |
| a_out | output | 12 | Data presented on port A |
| a_drive | output | 1 | Port A drive enable (registered) |
| even_in | input | 12 | Data arriving on the even bank port |
| even_out | output | 12 | Data presented on the even bank port |
| even_drive | output | 1 | Even bank port drive enable (registered) |
| odd_in | input | 12 | Data arriving on the odd bank port |
| odd_out | output | 12 | Data presented on the odd bank port |
| odd_drive | output | 1 | Odd bank port drive enable (registered) |
| a2even_ld_n | input | 1 | Load enable for the A-to-even register, active low |
| a2odd_ld_n | input | 1 | Load enable for the A-to-odd register, active low |
| even2a_ld_n | input | 1 | Load enable for the even-to-A register, active low |
| odd2a_ld_n | input | 1 | Load enable for the odd-to-A register, active low |
| ret_even_sel | input | 1 | Return-path select: 1 = even-to-A, 0 = odd-to-A |
| a_oe_n | input | 1 | Port A output enable, active low, synchronous |
| b_oe_n | input | 1 | Shared bank-port output enable, active low, synchronous |

## Verification
A register that loads when its enable is high, or misses a load, shows up on its bank output one cycle after the faulty edge. For the return registers, it shows up on `a_out` in the next cycle that selects that path. A return-path state stuck in one value, or one that follows the select without waiting for the edge, puts the wrong bank word on `a_out` at the next sample. An output-enable flag built from the live input instead of its flop disagrees with the bench in the sample taken just after the inputs are disturbed mid-cycle. All 128 combinations of the four load enables, the select and the two output enables are applied against an arithmetic model, so each of these faults appears within a few cycles.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    // Register channels of the exchanger
    typedef enum logic [1:0] {
        CH_A2EVEN = 2'd0,
        CH_A2ODD  = 2'd1,
        CH_EVEN2A = 2'd2,
        CH_ODD2A  = 2'd3
    } chan_e;

    localparam int NCH = 4;

    // Return-path state: which bank register drives port A
    typedef enum logic {
        RET_ODD  = 1'b0,
        RET_EVEN = 1'b1
    } ret_src_e;

endpackage

// File: rtl/xchg_hold_reg.sv
module xchg_hold_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!ld_n) begin
            q <= d;
        end
    end

    // R2 / R4 / R5 / R6: an active enable captures the input
    a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |=> q == $past(d));

    // R3: an inactive enable holds the contents
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> $stable(q));

endmodule

// File: rtl/xchg_enable_ctl.sv
module xchg_enable_ctl
    import xchg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ret_even_sel,
    input  logic     a_oe_n,
    input  logic     b_oe_n,
    output ret_src_e ret_src,
    output logic     a_drive,
    output logic     b_drive
);

    ret_src_e ret_src_q;
    ret_src_e ret_src_d;

    // Next-state logic for the return-path select
    always_comb begin
        ret_src_d = ret_src_q;
        unique case (ret_src_q)
            RET_ODD:  if (ret_even_sel)  ret_src_d = RET_EVEN;
            RET_EVEN: if (!ret_even_sel) ret_src_d = RET_ODD;
            default:  ret_src_d = RET_ODD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_src_q <= RET_ODD;
        end else begin
            ret_src_q <= ret_src_d;
        end
    end

    // Registered output-enable flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_drive <= 1'b0;
            b_drive <= 1'b0;
        end else begin
            a_drive <= ~a_oe_n;
            b_drive <= ~b_oe_n;
        end
    end

    assign ret_src = ret_src_q;

    // R8: port A enable follows the sampled input one edge later
    a_r8_a_enable_sync: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> a_drive == !$past(a_oe_n));

    // R9: a high shared enable floats the bank ports at the next edge
    a_r9_b_float: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |=> !b_drive);

    // R7: the state follows the sampled select
    a_r7_state_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ret_even_sel |=> ret_src_q == RET_EVEN);

endmodule

// File: rtl/dual_bank_exchanger.sv
module dual_bank_exchanger
    import xchg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] even_in,
    output logic [W-1:0] even_out,
    output logic         even_drive,
    input  logic [W-1:0] odd_in,
    output logic [W-1:0] odd_out,
    output logic         odd_drive,
    input  logic         a2even_ld_n,
    input  logic         a2odd_ld_n,
    input  logic         even2a_ld_n,
    input  logic         odd2a_ld_n,
    input  logic         ret_even_sel,
    input  logic         a_oe_n,
    input  logic         b_oe_n
);

    logic [NCH-1:0][W-1:0] ch_d;
    logic [NCH-1:0][W-1:0] ch_q;
    logic [NCH-1:0]        ch_ld_n;
    ret_src_e              ret_src;
    logic                  b_drive;

    assign ch_d[CH_A2EVEN]    = a_in;
    assign ch_d[CH_A2ODD]     = a_in;
    assign ch_d[CH_EVEN2A]    = even_in;
    assign ch_d[CH_ODD2A]     = odd_in;
    assign ch_ld_n[CH_A2EVEN] = a2even_ld_n;
    assign ch_ld_n[CH_A2ODD]  = a2odd_ld_n;
    assign ch_ld_n[CH_EVEN2A] = even2a_ld_n;
    assign ch_ld_n[CH_ODD2A]  = odd2a_ld_n;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        xchg_hold_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .ld_n  (ch_ld_n[c]),
            .d     (ch_d[c]),
            .q     (ch_q[c])
        );
    end

    xchg_enable_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_even_sel (ret_even_sel),
        .a_oe_n       (a_oe_n),
        .b_oe_n       (b_oe_n),
        .ret_src      (ret_src),
        .a_drive      (a_drive),
        .b_drive      (b_drive)
    );

    // Output selection: all sources are flops
    always_comb begin
        unique case (ret_src)
            RET_EVEN: a_out = ch_q[CH_EVEN2A];
            RET_ODD:  a_out = ch_q[CH_ODD2A];
            default:  a_out = '0;
        endcase
    end

    assign even_out   = ch_q[CH_A2EVEN];
    assign odd_out    = ch_q[CH_A2ODD];
    assign even_drive = b_drive;
    assign odd_drive  = b_drive;

    // R7: even path selected with a load returns the captured even word
    a_r7_return_even: assert property (@(posedge clk) disable iff (!rst_n)
        ret_even_sel && !even2a_ld_n |=> a_out == $past(even_in));

    // R7: odd path selected with a load returns the captured odd word
    a_r7_return_odd: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_even_sel && !odd2a_ld_n |=> a_out == $past(odd_in));

    // R2: the even bank port shows a word written from port A
    a_r2_even_write: assert property (@(posedge clk) disable iff (!rst_n)
        !a2even_ld_n |=> even_out == $past(a_in));

    // R9: both bank drive flags agree with the sampled shared enable
    a_r9_shared_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe_n |=> even_drive && odd_drive);

endmodule

// File: tb/test_dual_bank_exchanger.sv
module test_dual_bank_exchanger;

    localparam int W = 12;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, even_in = '0, odd_in = '0;
    logic [W-1:0] a_out, even_out, odd_out;
    logic         a_drive, even_drive, odd_drive;
    logic         a2even_ld_n = 1'b1, a2odd_ld_n = 1'b1;
    logic         even2a_ld_n = 1'b1, odd2a_ld_n = 1'b1;
    logic         ret_even_sel = 1'b0, a_oe_n = 1'b1, b_oe_n = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [W-1:0] m_even, m_odd, m_re, m_ro;
    logic         m_sel, m_ad, m_bd;

    always #4 clk = ~clk;

    dual_bank_exchanger #(.W(W)) i_dual_bank_exchanger (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .even_in(even_in), .even_out(even_out), .even_drive(even_drive),
        .odd_in(odd_in), .odd_out(odd_out), .odd_drive(odd_drive),
        .a2even_ld_n(a2even_ld_n), .a2odd_ld_n(a2odd_ld_n),
        .even2a_ld_n(even2a_ld_n), .odd2a_ld_n(odd2a_ld_n),
        .ret_even_sel(ret_even_sel), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [W-1:0] exp_a;
        exp_a = m_sel ? m_re : m_ro;
        chk({tag, " R2 R3 even_out"}, even_out, m_even);
        chk({tag, " R4 odd_out"}, odd_out, m_odd);
        chk({tag, " R5 R6 R7 R11 a_out"}, a_out, exp_a);
        chk({tag, " R8 a_drive"}, {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, m_ad});
        chk({tag, " R9 even_drive"}, {{(W-1){1'b0}}, even_drive}, {{(W-1){1'b0}}, m_bd});
        chk({tag, " R9 odd_drive"}, {{(W-1){1'b0}}, odd_drive}, {{(W-1){1'b0}}, m_bd});
    endtask

    // Apply inputs, advance one edge, check, then disturb inputs mid-cycle
    task automatic step(input logic [W-1:0] av, input logic [W-1:0] ev, input logic [W-1:0] ov,
                        input logic [3:0] ld_n, input logic sel, input logic aoe, input logic boe);
        a_in = av; even_in = ev; odd_in = ov;
        a2even_ld_n = ld_n[0]; a2odd_ld_n = ld_n[1];
        even2a_ld_n = ld_n[2]; odd2a_ld_n = ld_n[3];
        ret_even_sel = sel; a_oe_n = aoe; b_oe_n = boe;
        @(posedge clk);
        if (!ld_n[0]) m_even = av;
        if (!ld_n[1]) m_odd = av;
        if (!ld_n[2]) m_re = ev;
        if (!ld_n[3]) m_ro = ov;
        m_sel = sel; m_ad = ~aoe; m_bd = ~boe;
        #2;
        check_all("edge");
        // R10: inputs change between edges, outputs must not
        a_in = ~av; even_in = ~ev; odd_in = ~ov;
        a2even_ld_n = 1'b0; a2odd_ld_n = 1'b0; even2a_ld_n = 1'b0; odd2a_ld_n = 1'b0;
        ret_even_sel = ~sel; a_oe_n = ~aoe; b_oe_n = ~boe;
        #1;
        check_all("R10 mid-cycle");
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_even = '0; m_odd = '0; m_re = '0; m_ro = '0;
        m_sel = 1'b0; m_ad = 1'b0; m_bd = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_all("R1 after release");

        // Directed: write even, write odd, read back both banks
        step(12'h5A3, 12'h000, 12'h000, 4'b1110, 1'b0, 1'b0, 1'b0); // R2 write even
        step(12'h0C7, 12'h000, 12'h000, 4'b1101, 1'b0, 1'b0, 1'b0); // R4 write odd, R3 even holds
        chk("R3 even kept", even_out, 12'h5A3);
        chk("R4 odd written", odd_out, 12'h0C7);
        step(12'h000, 12'hABC, 12'h123, 4'b0011, 1'b1, 1'b0, 1'b1); // R5 R6 load returns, even path
        chk("R7 even path", a_out, 12'hABC);
        step(12'h000, 12'h000, 12'h000, 4'b1111, 1'b0, 1'b1, 1'b1); // R7 odd path, R8 float A
        chk("R6 R7 odd path", a_out, 12'h123);
        chk("R11 data with A floated", a_out, 12'h123);

        // Near-exhaustive sweep over enables, select and output enables
        for (int i = 0; i < 128; i++) begin
            logic [6:0] c;
            c = 7'(i);
            step(12'((i * 37 + 5)) & MASK, 12'((i * 91 + 300)) & MASK, 12'((i * 53 + 2049)) & MASK,
                 c[3:0], c[4], c[5], c[6]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule